// File: doc/BRIEF.md
# Two-Modulus Prescaler Swallow Controller

This block sits in the feedback path of a frequency synthesizer. It drives an external prescaler that divides the oscillator by P or by P+1. It is clocked by the prescaler output, so every rising edge of `clk` is one prescaler period. A main counter counts the N prescaler periods of one synthesizer division cycle. A swallow counter runs alongside it during the first A of those periods.

While the swallow count is still running, the modulus line is held low and the prescaler divides by P+1. Once the swallow count is used up, the line goes high and the prescaler divides by P for the remaining N−A periods. At the end of the cycle both counters reload and a one-period strobe marks the divided edge for the phase detector. One cycle therefore spans N·P + A oscillator periods.

The N and A values are written through a parallel load port into holding registers. The counters read those registers only when they reload at a cycle boundary.

Top module: `swallow_ctrl`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, `fb_strobe` goes low. The modulus line takes the level implied by the reset swallow value. With the default reset values (N=4, A=1), `mod_hi` reads 0.
- R2: In every cycle with A > 0, `mod_hi` is 0 (prescaler divides by P+1) for exactly the first A prescaler periods, starting at the first period of the cycle.
- R3: After the swallow periods, `mod_hi` is 1 (prescaler divides by P) for the remaining N−A periods. It never returns to 0 before the cycle ends.
- R4: `fb_strobe` is high for exactly one prescaler period per cycle: the first period after the cycle-ending edge. Consecutive strobes are N periods apart (N ≥ 2).
- R5: With a prescaler that divides by P when `mod_hi` is 1 and by P+1 when it is 0, one cycle covers N·P + A prescaler input periods.
- R6: With A = 0, `mod_hi` is 1 for all N periods of the cycle, and the cycle covers N·P periods.
- R7: With A = N, `mod_hi` stays 0 for all N periods of the cycle, and the cycle covers N·(P+1) periods.
- R8: A load in the middle of a cycle does not change that cycle. The new N and A take effect only at the next reload.
- R9: With `CLAMP_A` = 1 (the default), a loaded A larger than the loaded N is stored as N. The cycle then behaves as the case A = N.
- R10: When `ld_en` is low, the values on `ld_n` and `ld_a` are ignored. The stored N and A keep governing every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output; one rising edge per prescaler period |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Writes `ld_n`/`ld_a` into the holding registers on this edge |
| ld_n | input | NW | Main count N to hold (N ≥ 2) |
| ld_a | input | AW | Swallow count A to hold |
| mod_hi | output | 1 | Modulus control: 1 selects divide by P, 0 selects divide by P+1 |
| fb_strobe | output | 1 | One-period divided feedback strobe at the start of each cycle |

## Verification
The assertions take for granted that the stored N is at least 2, and that A never exceeds N when `CLAMP_A` is 0. Under these conditions the swallow count cannot outlast the main count and the strobe cannot merge across cycles. The stimulus only loads N values from 5 to 10. The single A above N is loaded with clamping enabled. The prescaler model has P ≥ 2 and holds the sampled modulus for a whole prescaler period, the same way a real two-modulus divider does. After every load, the scoreboard ignores the next two cycle boundaries. This covers a period in which the model's P changed partway through a cycle.

// File: rtl/swallow_pkg.sv
// Package: shared definitions for the swallow controller.
// Assumes nothing beyond being compiled before the modules that import it.
package swallow_pkg;

    // Level of the modulus-control line and the divide ratio it selects.
    typedef enum logic {
        MC_SWALLOW = 1'b0,  // prescaler divides by P+1
        MC_BASE    = 1'b1   // prescaler divides by P
    } mc_level_e;

    // Pick the modulus level for a given remaining swallow count.
    function automatic mc_level_e level_for(input logic swallow_left);
        return swallow_left ? MC_SWALLOW : MC_BASE;
    endfunction

endpackage

// File: rtl/swallow_prog_regs.sv
// Holding registers for N and A, written through the parallel load port.
// With CLAMP_A set, an A above N is stored as N, so the swallow count never outlasts the main count.
// Assumes AW <= NW.
module swallow_prog_regs #(
    parameter int NW      = 8,
    parameter int AW      = 8,
    parameter int N_RST   = 4,
    parameter int A_RST   = 1,
    parameter bit CLAMP_A = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [NW-1:0] ld_n,
    input  logic [AW-1:0] ld_a,
    output logic [NW-1:0] hold_n,
    output logic [AW-1:0] hold_a
);

    logic [AW-1:0] a_in;

    // Choose the A value to store: clamped to N or taken as written.
    generate
        if (CLAMP_A) begin : g_clamp
            assign a_in = (NW'(ld_a) > ld_n) ? AW'(ld_n) : ld_a;
        end else begin : g_raw
            assign a_in = ld_a;
        end
    endgenerate

    // Capture new N and A on a load edge; reset restores the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_n <= NW'(N_RST);
            hold_a <= AW'(A_RST);
        end else if (ld_en) begin
            hold_n <= ld_n;
            hold_a <= a_in;
        end
    end

endmodule

// File: rtl/swallow_main_cnt.sv
// Main down-counter: counts the N prescaler periods of one division cycle.
// `last` flags the final period, and the counter reloads from the held N on that edge.
// Assumes the held N is at least 1.
module swallow_main_cnt #(
    parameter int NW    = 8,
    parameter int N_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] hold_n,
    output logic [NW-1:0] n_rem,
    output logic          last
);

    assign last = (n_rem == NW'(1));

    // Count down one per prescaler period; reload at the cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_rem <= NW'(N_RST);
        end else if (last) begin
            n_rem <= hold_n;
        end else begin
            n_rem <= n_rem - NW'(1);
        end
    end

endmodule

// File: rtl/swallow_aux_cnt.sv
// Swallow down-counter and modulus-control register.
// The modulus line is low while swallow periods remain and high once they are used up.
// Both reload with the main counter. Assumes the held A does not exceed the held N.
module swallow_aux_cnt
    import swallow_pkg::*;
#(
    parameter int AW    = 8,
    parameter int A_RST = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last,
    input  logic [AW-1:0] hold_a,
    output logic [AW-1:0] a_rem,
    output logic          mod_hi
);

    mc_level_e level_q;

    assign mod_hi = (level_q == MC_BASE);

    // Step the swallow count and set the modulus level for the next period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rem   <= AW'(A_RST);
            level_q <= level_for(A_RST != 0);
        end else if (last) begin
            a_rem   <= hold_a;
            level_q <= level_for(hold_a != '0);
        end else if (a_rem != '0) begin
            a_rem   <= a_rem - AW'(1);
            level_q <= level_for(a_rem != AW'(1));
        end
    end

endmodule

// File: rtl/swallow_ctrl.sv
// Top of the swallow controller. It is clocked by the prescaler output.
// Drives the modulus line and emits one feedback strobe per N-period division cycle.
// Assumes the held N >= 2 and A <= N.
module swallow_ctrl #(
    parameter int NW      = 8,
    parameter int AW      = 8,
    parameter int N_RST   = 4,
    parameter int A_RST   = 1,
    parameter bit CLAMP_A = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [NW-1:0] ld_n,
    input  logic [AW-1:0] ld_a,
    output logic          mod_hi,
    output logic          fb_strobe
);

    logic [NW-1:0] hold_n;
    logic [AW-1:0] hold_a;
    logic [NW-1:0] n_rem;
    logic [AW-1:0] a_rem;
    logic          last;

    swallow_prog_regs #(
        .NW(NW), .AW(AW), .N_RST(N_RST), .A_RST(A_RST), .CLAMP_A(CLAMP_A)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_n(ld_n), .ld_a(ld_a),
        .hold_n(hold_n), .hold_a(hold_a)
    );

    swallow_main_cnt #(.NW(NW), .N_RST(N_RST)) u_main (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .n_rem(n_rem), .last(last)
    );

    swallow_aux_cnt #(.AW(AW), .A_RST(A_RST)) u_aux (
        .clk(clk), .rst_n(rst_n), .last(last), .hold_a(hold_a),
        .a_rem(a_rem), .mod_hi(mod_hi)
    );

    // Register the cycle-end flag as the feedback strobe for the next period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_strobe <= 1'b0;
        end else begin
            fb_strobe <= last;
        end
    end

endmodule

// File: rtl/swallow_ctrl_chk.sv
// Checker for the swallow controller, attached by bind below.
// Assumes the held N >= 2 and A <= N.
module swallow_ctrl_chk #(
    parameter int NW = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mod_hi,
    input logic          fb_strobe,
    input logic [NW-1:0] n_rem,
    input logic [AW-1:0] a_rem
);

    AST_SWALLOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rem != '0) |-> !mod_hi);  // R2

    AST_MC_FALL_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_hi) |-> fb_strobe);  // R3

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_strobe |=> !fb_strobe);  // R4

    AST_RELOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (n_rem == NW'(1)) |=> fb_strobe);  // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (n_rem > NW'(1)) |=> (n_rem == NW'($past(n_rem) - NW'(1))));  // R8

    AST_A_WITHIN_N: assert property (@(posedge clk) disable iff (!rst_n)
        NW'(a_rem) <= n_rem);  // R9

endmodule

bind swallow_ctrl swallow_ctrl_chk #(.NW(NW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mod_hi(mod_hi), .fb_strobe(fb_strobe),
    .n_rem(n_rem), .a_rem(a_rem)
);

// File: tb/swallow_ctrl_tb.sv
// Scoreboard bench: models the two-modulus prescaler on a 250 MHz oscillator clock.
// The driver pushes the expected cycle shape; the monitor measures each cycle and compares.
module swallow_ctrl_tb;

    typedef struct {
        int    tot;
        int    n;
        int    a;
        string tag;
    } exp_t;

    logic       vco = 1'b0;
    logic       psc = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_n = '0;
    logic [7:0] ld_a = '0;
    logic       mod_hi;
    logic       fb_strobe;

    int   p_cur = 4;
    int   tgt = 4;
    int   cnt = 0;
    int   vco_n = 0;
    int   last_v = 0;
    int   lows = 0;
    int   highs = 0;
    bit   ord_bad = 1'b0;
    bit   started = 1'b0;
    bit   prev_strobe = 1'b0;
    int   discard = 0;
    int   total = 0;
    int   bad = 0;
    exp_t q[$];

    swallow_ctrl u_dut (
        .clk(psc), .rst_n(rst_n), .ld_en(ld_en), .ld_n(ld_n), .ld_a(ld_a),
        .mod_hi(mod_hi), .fb_strobe(fb_strobe)
    );

    always #2 vco = ~vco;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Prescaler model and monitor, both on the oscillator clock.
    always @(posedge vco) begin
        vco_n++;
        if (psc) begin
            tgt = mod_hi ? p_cur : p_cur + 1;
            cnt = 1;
            psc <= 1'b0;
            if (rst_n) begin
                if (fb_strobe) begin
                    check(!prev_strobe, "R4 strobe width", 2, 1);
                    if (started) begin
                        if (discard > 0) begin
                            discard--;
                        end else if (q.size() > 0) begin
                            exp_t it;
                            it = q.pop_front();
                            check(vco_n - last_v == it.tot, it.tag, vco_n - last_v, it.tot);
                            check(lows == it.a, (it.a == it.n) ? "R7" : "R2", lows, it.a);
                            check(highs == it.n - it.a, (it.a == 0) ? "R6" : "R3", highs, it.n - it.a);
                            check(lows + highs == it.n, "R4 periods", lows + highs, it.n);
                            check(!ord_bad, "R3 order", int'(ord_bad), 0);
                        end
                    end
                    started = 1'b1;
                    last_v  = vco_n;
                    lows    = 0;
                    highs   = 0;
                    ord_bad = 1'b0;
                end
                if (mod_hi) highs++;
                else begin
                    lows++;
                    if (highs > 0) ord_bad = 1'b1;
                end
                prev_strobe = fb_strobe;
            end
        end else begin
            cnt++;
            if (cnt >= tgt) psc <= 1'b1;
        end
    end

    task automatic load(input int n, input int a, input int p);
        @(posedge psc);
        @(negedge vco);
        ld_en = 1'b1;
        ld_n  = 8'(n);
        ld_a  = 8'(a);
        p_cur = p;
        discard = 2;
        @(posedge psc);
        @(negedge vco);
        ld_en = 1'b0;
    endtask

    task automatic expect_cycles(input int n, input int a, input int p, input string tag, input int k);
        for (int i = 0; i < k; i++) begin
            exp_t it;
            it.tot = n * p + a;
            it.n = n;
            it.a = a;
            it.tag = tag;
            q.push_back(it);
        end
        wait (q.size() == 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge vco);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (30) @(negedge vco);
        check(mod_hi == 1'b0, "R1 mod_hi", int'(mod_hi), 0);
        check(fb_strobe == 1'b0, "R1 strobe", int'(fb_strobe), 0);
        rst_n = 1'b1;

        expect_cycles(4, 1, 4, "R5 reset values", 3);
        load(10, 3, 4);  expect_cycles(10, 3, 4, "R5", 3);
        load(7, 2, 5);   expect_cycles(7, 2, 5, "R5", 3);
        load(6, 0, 3);   expect_cycles(6, 0, 3, "R6", 3);
        load(5, 5, 2);   expect_cycles(5, 5, 2, "R7", 3);
        load(6, 9, 4);   expect_cycles(6, 6, 4, "R9 clamp", 3);

        // R10: data wiggles with ld_en low; the stored 6/6 must persist.
        for (int i = 0; i < 40; i++) begin
            @(negedge vco);
            ld_n = 8'(i + 2);
            ld_a = 8'(i);
        end
        expect_cycles(6, 6, 4, "R10", 3);

        // R8: a load in period 0 must not cut the running swallow count short.
        load(8, 5, 4);   expect_cycles(8, 5, 4, "R5", 2);
        do @(negedge vco); while (!fb_strobe);
        ld_en = 1'b1;
        ld_n  = 8'd8;
        ld_a  = 8'd0;
        discard = 2;
        @(posedge psc);
        @(negedge vco);
        ld_en = 1'b0;
        check(mod_hi == 1'b0, "R8 period1", int'(mod_hi), 0);
        @(posedge psc);
        @(negedge vco);
        check(mod_hi == 1'b0, "R8 period2", int'(mod_hi), 0);
        expect_cycles(8, 0, 4, "R8", 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule